// File: doc/BRIEF.md
# Double-Buffered Clocked Serial Transmitter

This block sends bytes over a clocked serial link. Software writes a byte into a one-byte holding register and then clears the data-empty flag. The transmitter then copies the byte into its own shift register and sets the empty flag again at once. This leaves the holding register free for the next byte while the current one is still shifting out. Bits leave least significant first. The data line changes on the falling edge of the serial clock, so it is stable on the rising edge.

The serial clock can come from an internal fixed divider, which drives the clock pin. It can also come from an external clock input, and in that case the clock output stays high. The empty flag is sampled once per frame, in the bit-clock step that puts the last bit on the line. If software has already cleared the flag, the next byte follows with no idle gap. If the flag is still set, the transmit-end flag is raised, the data line keeps the last bit and the clock stops high. Two level interrupt requests are each formed from a flag and its enable bit.

Top module: `sync_ser_tx`

## Requirements
- R1: After reset, empty_flag=1, end_flag=1, sdata=1, sclk_out=1, and both interrupt requests are 0 because the control register resets to 0.
- R2: A pulse on empty_clr while the transmitter is idle starts a frame. The holding byte is copied into the shift register and empty_flag reads 1 again two clock cycles after the pulse.
- R3: irq_empty equals empty_flag AND ctrl bit 0, and irq_end equals end_flag AND ctrl bit 1. Both are levels. ctrl_wdata bit 2 selects the external clock when it is 1.
- R4: In internal clock mode every frame gives exactly 8 rising edges on sclk_out. The bits sampled on those edges are the byte, bit 0 first. sdata changes only while sclk_out falls.
- R5: In internal clock mode each sclk_out level lasts DIV_HALF clock cycles, so rising edges within a frame are 2*DIV_HALF cycles apart.
- R6: If empty_flag is 0 when the last bit goes out, the next byte follows with no gap. The first rising edge of the new frame comes 2*DIV_HALF cycles after the last rising edge of the old one.
- R7: If empty_flag is 1 when the last bit goes out, end_flag becomes 1, sdata keeps bit 7 of the byte and sclk_out stays high until the next frame.
- R8: In external clock mode each synchronized falling edge of sclk_in puts the next bit on sdata, and sclk_out stays at 1.
- R9: empty_clr also clears end_flag. end_flag falls only on empty_clr, and empty_flag falls only on empty_clr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hold_we | input | 1 | Write strobe for the holding register |
| hold_wdata | input | DATA_W | Byte to transmit |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 3 | bit0 empty-irq enable, bit1 end-irq enable, bit2 external clock |
| empty_clr | input | 1 | Software clear of the empty flag (also clears end flag) |
| empty_flag | output | 1 | Holding register free for a new byte |
| end_flag | output | 1 | Transmission finished, line idle |
| sclk_in | input | 1 | External serial clock |
| sclk_out | output | 1 | Generated serial clock, idles high |
| sdata | output | 1 | Serial data |
| irq_empty | output | 1 | Empty interrupt request |
| irq_end | output | 1 | End interrupt request |

## Verification
A wrong bit counter or shift register shows up as a wrong byte at the end of the first frame, within 16*DIV_HALF cycles. A late or missed sample of the empty flag shows up either as a gap between chained frames, visible as one oversized interval between rising edges, or as end_flag rising while a byte is still waiting. A divider or clock-mux fault appears on the first half period as a wrong interval or as stray pulses in external mode. A fault in the flags shows up two cycles after a clear as a wrong empty or end level.

// File: rtl/sst_pkg.sv
package sst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LAST  = 2'd2
    } sst_state_e;

    localparam int CTRL_W       = 3;
    localparam int CTRL_EMPTYIE = 0;
    localparam int CTRL_ENDIE   = 1;
    localparam int CTRL_EXTCLK  = 2;
endpackage

// File: rtl/sst_regs.sv
module sst_regs
    import sst_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_we,
    input  logic [DATA_W-1:0] hold_wdata,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [DATA_W-1:0] hold_byte,
    output logic              empty_ie,
    output logic              end_ie,
    output logic              ext_sel
);
    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic [CTRL_W-1:0] ctrl;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (hold_we) r_d.hold = hold_wdata;
        if (ctrl_we) r_d.ctrl = ctrl_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.hold <= '0;
            r_q.ctrl <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign hold_byte = r_q.hold;
    assign empty_ie  = r_q.ctrl[CTRL_EMPTYIE];
    assign end_ie    = r_q.ctrl[CTRL_ENDIE];
    assign ext_sel   = r_q.ctrl[CTRL_EXTCLK];
endmodule

// File: rtl/sst_bitclk.sv
module sst_bitclk #(
    parameter int DIV_HALF    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ext_sel,
    input  logic sclk_in,
    output logic sclk_out,
    output logic fall_evt,
    output logic rise_evt
);
    localparam int DIV_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_HALF - 1);

    typedef struct packed {
        logic [DIV_W-1:0]       div;
        logic                   sclk;
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } clk_t;

    clk_t c_d, c_q;
    logic ext_now;
    logic int_toggle;

    assign ext_now    = c_q.sync[SYNC_STAGES-1];
    assign int_toggle = run && !ext_sel && (c_q.div == DIV_LAST);

    always_comb begin
        c_d      = c_q;
        c_d.sync = {c_q.sync[SYNC_STAGES-2:0], sclk_in};
        c_d.prev = ext_now;
        if (!run || ext_sel) begin
            c_d.div  = '0;
            c_d.sclk = 1'b1;
        end else if (int_toggle) begin
            c_d.div  = '0;
            c_d.sclk = !c_q.sclk;
        end else begin
            c_d.div = c_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.div  <= '0;
            c_q.sclk <= 1'b1;
            c_q.sync <= '1;
            c_q.prev <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    always_comb begin
        if (ext_sel) begin
            fall_evt = c_q.prev && !ext_now;
            rise_evt = !c_q.prev && ext_now;
        end else begin
            fall_evt = int_toggle && c_q.sclk;
            rise_evt = int_toggle && !c_q.sclk;
        end
    end

    assign sclk_out = c_q.sclk;
endmodule

// File: rtl/sst_engine.sv
module sst_engine
    import sst_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] hold_byte,
    input  logic              empty_clr,
    input  logic              fall_evt,
    input  logic              rise_evt,
    output logic              busy,
    output logic              sdata,
    output logic              empty_flag,
    output logic              end_flag
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        sst_state_e        state;
        logic [DATA_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              line;
        logic              empty;
        logic              tend;
    } eng_t;

    eng_t e_d, e_q;

    always_comb begin
        e_d = e_q;
        if (empty_clr) begin
            e_d.empty = 1'b0;
            e_d.tend  = 1'b0;
        end
        unique case (e_q.state)
            ST_IDLE: begin
                if (!e_q.empty) begin
                    e_d.shreg = hold_byte;
                    e_d.empty = 1'b1;
                    e_d.cnt   = '0;
                    e_d.state = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (fall_evt) begin
                    e_d.line  = e_q.shreg[0];
                    e_d.shreg = e_q.shreg >> 1;
                    if (e_q.cnt == CNT_LAST) begin
                        if (!e_q.empty) begin
                            e_d.shreg = hold_byte;
                            e_d.empty = 1'b1;
                            e_d.cnt   = '0;
                        end else begin
                            e_d.tend  = 1'b1;
                            e_d.state = ST_LAST;
                        end
                    end else begin
                        e_d.cnt = e_q.cnt + 1'b1;
                    end
                end
            end
            ST_LAST: begin
                if (rise_evt) e_d.state = ST_IDLE;
            end
            default: e_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q.state <= ST_IDLE;
            e_q.shreg <= '0;
            e_q.cnt   <= '0;
            e_q.line  <= 1'b1;
            e_q.empty <= 1'b1;
            e_q.tend  <= 1'b1;
        end else begin
            e_q <= e_d;
        end
    end

    assign busy       = (e_q.state != ST_IDLE);
    assign sdata      = e_q.line;
    assign empty_flag = e_q.empty;
    assign end_flag   = e_q.tend;
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx
    import sst_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_HALF    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_we,
    input  logic [DATA_W-1:0] hold_wdata,
    input  logic              ctrl_we,
    input  logic [2:0]        ctrl_wdata,
    input  logic              empty_clr,
    output logic              empty_flag,
    output logic              end_flag,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sdata,
    output logic              irq_empty,
    output logic              irq_end
);
    logic [DATA_W-1:0] hold_byte;
    logic empty_ie, end_ie, ext_sel;
    logic busy, fall_evt, rise_evt;

    sst_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .hold_we(hold_we), .hold_wdata(hold_wdata),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .hold_byte(hold_byte), .empty_ie(empty_ie),
        .end_ie(end_ie), .ext_sel(ext_sel)
    );

    sst_bitclk #(.DIV_HALF(DIV_HALF), .SYNC_STAGES(SYNC_STAGES)) u_bitclk (
        .clk(clk), .rst_n(rst_n), .run(busy), .ext_sel(ext_sel),
        .sclk_in(sclk_in), .sclk_out(sclk_out),
        .fall_evt(fall_evt), .rise_evt(rise_evt)
    );

    sst_engine #(.DATA_W(DATA_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .hold_byte(hold_byte),
        .empty_clr(empty_clr), .fall_evt(fall_evt), .rise_evt(rise_evt),
        .busy(busy), .sdata(sdata),
        .empty_flag(empty_flag), .end_flag(end_flag)
    );

    assign irq_empty = empty_flag & empty_ie;
    assign irq_end   = end_flag & end_ie;
endmodule

// File: rtl/sst_tx_chk.sv
module sst_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic ext_sel,
    input logic sclk_out,
    input logic sdata,
    input logic empty_flag,
    input logic end_flag,
    input logic empty_clr,
    input logic irq_end
);
    p_data_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_sel && $past(!ext_sel) && sclk_out && $past(sclk_out)) |-> $stable(sdata));

    p_idle_clock_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk_out);

    p_end_when_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_flag) |-> $past(empty_flag));

    p_ext_no_clock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_sel && $past(ext_sel)) |-> sclk_out);

    p_end_clear_only_sw_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(end_flag) |-> $past(empty_clr));

    p_empty_clear_only_sw_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(empty_flag) |-> $past(empty_clr));

    p_irq_end_needs_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_end |-> end_flag);
endmodule

bind sync_ser_tx sst_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .ext_sel(ext_sel),
    .sclk_out(sclk_out), .sdata(sdata), .empty_flag(empty_flag),
    .end_flag(end_flag), .empty_clr(empty_clr), .irq_end(irq_end)
);

// File: tb/tb_sync_ser_tx.sv
`timescale 1ns/1ps
module tb_sync_ser_tx;
    localparam int DW   = 8;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_we = 1'b0;
    logic [DW-1:0] hold_wdata = '0;
    logic ctrl_we = 1'b0;
    logic [2:0] ctrl_wdata = '0;
    logic empty_clr = 1'b0;
    logic sclk_in = 1'b1;
    logic empty_flag, end_flag, sclk_out, sdata, irq_empty, irq_end;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [DW-1:0] exp_q[$];
    int rise_cyc[$];
    logic [DW-1:0] cap;
    int nbits = 0;
    logic sclk_prev = 1'b1;

    always #2 clk = ~clk;

    sync_ser_tx #(.DATA_W(DW), .DIV_HALF(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .hold_we(hold_we), .hold_wdata(hold_wdata),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .empty_clr(empty_clr),
        .empty_flag(empty_flag), .end_flag(end_flag), .sclk_in(sclk_in),
        .sclk_out(sclk_out), .sdata(sdata), .irq_empty(irq_empty), .irq_end(irq_end)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: samples at negedge, collects bits on sclk_out rising (R4)
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (sclk_out && !sclk_prev) begin
                rise_cyc.push_back(cyc);
                cap[nbits] = sdata;
                nbits++;
                if (nbits == DW) begin
                    nbits = 0;
                    if (exp_q.size() == 0) chk(1'b0, "R4 unexpected frame", cap, 0);
                    else begin
                        logic [DW-1:0] e;
                        e = exp_q.pop_front();
                        chk(cap == e, "R4 frame byte", cap, e);
                    end
                end
            end
            sclk_prev = sclk_out;
        end
    end

    task automatic wr_hold(input logic [DW-1:0] b);
        @(negedge clk); hold_we = 1'b1; hold_wdata = b;
        @(negedge clk); hold_we = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [2:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic send(input logic [DW-1:0] b, input bit track);
        wr_hold(b);
        if (track) exp_q.push_back(b);
        @(negedge clk); empty_clr = 1'b1;
        @(negedge clk); empty_clr = 1'b0;
    endtask

    task automatic wait_end(input string req);
        int k;
        for (k = 0; k < 2000 && !end_flag; k++) @(negedge clk);
        chk(end_flag == 1'b1, req, end_flag, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] xb;
        int r0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(empty_flag == 1, "R1 empty after reset", empty_flag, 1);
        chk(end_flag == 1, "R1 end after reset", end_flag, 1);
        chk(sdata == 1, "R1 sdata after reset", sdata, 1);
        chk(sclk_out == 1, "R1 sclk after reset", sclk_out, 1);
        chk(irq_empty == 0 && irq_end == 0, "R1 irqs after reset", {irq_empty, irq_end}, 0);

        wr_ctrl(3'b011);
        @(negedge clk);
        chk(irq_empty == 1 && irq_end == 1, "R3 irqs follow flags", {irq_empty, irq_end}, 3);

        // single frame, internal clock
        send(8'hA5, 1'b1);
        @(negedge clk);
        chk(empty_flag == 1, "R2 empty set again after load", empty_flag, 1);
        chk(end_flag == 0, "R9 end cleared by empty_clr", end_flag, 0);
        chk(irq_end == 0, "R3 irq_end low with flag", irq_end, 0);
        chk(irq_empty == 1, "R3 irq_empty after load", irq_empty, 1);
        wait_end("R7 end after single frame");
        repeat (3 * HALF) @(negedge clk);
        chk(sdata == 1'b1, "R7 line holds bit7 of A5", sdata, 1);
        chk(sclk_out == 1, "R7 clock idle high", sclk_out, 1);
        chk(rise_cyc.size() == 8, "R4 eight pulses", rise_cyc.size(), 8);
        chk(rise_cyc[1] - rise_cyc[0] == 2 * HALF, "R5 bit period", rise_cyc[1] - rise_cyc[0], 2 * HALF);
        chk(exp_q.size() == 0, "R4 frame delivered", exp_q.size(), 0);

        // chained frames
        r0 = rise_cyc.size();
        send(8'h3C, 1'b1);
        send(8'h43, 1'b1);
        wait_end("R7 end after chain");
        repeat (3 * HALF) @(negedge clk);
        chk(rise_cyc.size() == r0 + 16, "R6 sixteen pulses chained", rise_cyc.size() - r0, 16);
        chk(rise_cyc[r0 + 8] - rise_cyc[r0 + 7] == 2 * HALF, "R6 no gap between frames",
            rise_cyc[r0 + 8] - rise_cyc[r0 + 7], 2 * HALF);
        chk(sdata == 1'b0, "R7 line holds bit7 of 43", sdata, 0);
        chk(exp_q.size() == 0, "R4 both frames delivered", exp_q.size(), 0);

        // enables off
        wr_ctrl(3'b000);
        @(negedge clk);
        chk(irq_empty == 0 && irq_end == 0, "R3 irqs masked", {irq_empty, irq_end}, 0);

        // external clock
        wr_ctrl(3'b100);
        r0 = rise_cyc.size();
        xb = 8'h96;
        send(xb, 1'b0);
        repeat (4) @(negedge clk);
        for (int i = 0; i < DW; i++) begin
            sclk_in = 1'b0;
            repeat (8) @(negedge clk);
            chk(sdata == xb[i], "R8 external bit", sdata, xb[i]);
            chk(sclk_out == 1, "R8 clock output quiet", sclk_out, 1);
            sclk_in = 1'b1;
            repeat (8) @(negedge clk);
        end
        chk(end_flag == 1, "R7 end in external mode", end_flag, 1);
        chk(rise_cyc.size() == r0, "R8 no pulses on sclk_out", rise_cyc.size() - r0, 0);
        repeat (10) @(negedge clk);
        chk(end_flag == 1 && sdata == 1'b1, "R9 end held until clear", {end_flag, sdata}, 3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule